// File: doc/BRIEF.md
# Fully-Associative Translation Cache with Address-Space Tags and Entry Locking

This block holds a small set of recent virtual-to-physical page translations and looks all of them up in parallel. Every lookup presents a virtual address and the current address-space identifier. One cycle later the block returns either a physical address with the protection group and attribute bits of the matching entry, or a miss. The page-table walk and any fault handling are outside the block. When software finds a miss it writes the missing translation through the refill port. Instruction fetch and data access each use their own copy of the block.

Each entry covers a page of one of four sizes, and the size sets how many low address bits are passed through untranslated. An entry can be marked global so that it matches under every address space. Software can drop every entry at once, or drop only the entries covering one address. A lock control marks newly refilled entries as locked, and locked entries are never evicted by the round-robin replacement pointer. When translation is switched off, each address is returned unchanged.

Top module: `tlb_assoc`

## Requirements
- R1: After reset every entry is invalid and unlocked, the replacement pointer is at entry 0, and `res_valid`, `res_hit`, `res_paddr`, `res_group`, `res_attr`, `res_multi` and `fill_drop` are all 0. A lookup made after reset misses.
- R2: A lookup presented with `lk_valid` high in one cycle produces `res_valid` high in the next cycle. When `lk_valid` was low, every result output is 0 in the next cycle.
- R3: An entry hits when it is valid, its address-space ID equals `lk_asid` or its global bit is set, and the virtual address matches above the page offset. Page-size codes are 0=4 KB (12 offset bits), 1=16 KB (14), 2=512 KB (19) and 3=8 MB (23). On a hit, `res_paddr` takes the entry's physical bits above the offset and the lookup address bits within the offset.
- R4: On a hit, `res_group` and `res_attr` carry the entry's protection group and attribute bits. On a miss with translation on, `res_hit`, `res_paddr`, `res_group` and `res_attr` are 0.
- R5: With `xlate_en` low, a lookup returns `res_hit`=1 and `res_paddr` equal to the lookup address, with group, attribute and `res_multi` at 0.
- R6: `inv_all` clears the valid and lock state of every entry.
- R7: `inv_one` clears the valid and lock state of every entry whose page covers `inv_vaddr`, whatever its address-space ID. Other entries are kept.
- R8: A refill writes the first unlocked entry found by searching upward, with wrap-around, from the replacement pointer. The pointer then moves to the entry after the one written. `inv_all` leaves the pointer unchanged. A refill made while `lock_ctl` is high locks the written entry.
- R9: When every entry is locked, a refill writes nothing, and `fill_drop` is high for one cycle in the following cycle.
- R10: Only one table command acts per cycle. `inv_all` takes precedence over `inv_one`, which takes precedence over `fill_en`, and the lower commands have no effect.
- R11: When more than one entry hits, `res_multi` is 1 and the result comes from the lowest-numbered matching entry.
- R12: A lookup made in the same cycle as a table change sees the table as it was before that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | Translation enable; low means pass-through |
| lock_ctl | input | 1 | Lock entries written by refills while high |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | AW | Lookup virtual address |
| lk_asid | input | IDW | Current address-space ID |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_hit | output | 1 | Translation found (or pass-through) |
| res_paddr | output | AW | Physical address |
| res_group | output | GW | Protection group of the hit entry |
| res_attr | output | ATW | Attribute bits of the hit entry |
| res_multi | output | 1 | More than one entry matched |
| fill_en | input | 1 | Refill command |
| fill_vaddr | input | AW | Refill virtual address |
| fill_paddr | input | AW | Refill physical address |
| fill_asid | input | IDW | Refill address-space ID |
| fill_size | input | 2 | Refill page-size code |
| fill_global | input | 1 | Refill entry matches every ID |
| fill_group | input | GW | Refill protection group |
| fill_attr | input | ATW | Refill attribute bits |
| fill_drop | output | 1 | Refill dropped, all entries locked |
| inv_all | input | 1 | Invalidate every entry |
| inv_one | input | 1 | Invalidate entries covering `inv_vaddr` |
| inv_vaddr | input | AW | Address for single invalidation |

## Verification
The bench builds the block with its default parameters: 8 entries, 32-bit addresses, 4-bit IDs and groups, and 2-bit attributes. With only eight entries, a run of nine refills walks the replacement pointer through a full wrap. Locking two entries, and then all eight, shows both skipping and dropping. All sixteen address-space IDs are swept against per-ID and global entries, and each of the four page sizes is probed at its first byte, its last byte and the byte just past the page. Overlapping pages are used to force multiple hits.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_16K  = 2'd1,
    PG_512K = 2'd2,
    PG_8M   = 2'd3
  } pg_size_e;

  // number of untranslated low address bits for a page-size code
  function automatic logic [4:0] pg_shift(logic [1:0] sz);
    case (sz)
      2'd0:    return 5'd12;
      2'd1:    return 5'd14;
      2'd2:    return 5'd19;
      default: return 5'd23;
    endcase
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N   = 8,
  parameter int AW  = 32,
  parameter int IDW = 4
) (
  input  logic [N-1:0]   valid,
  input  logic [N-1:0]   glob,
  input  logic [AW-1:0]  tag  [N],
  input  logic [IDW-1:0] id   [N],
  input  logic [1:0]     size [N],
  input  logic [AW-1:0]  q_va,
  input  logic [IDW-1:0] q_id,
  input  logic           use_id,
  output logic [N-1:0]   hits
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [AW-1:0] keep;
    logic          id_ok;
    assign keep    = ~((AW'(1) << tlb_pkg::pg_shift(size[i])) - AW'(1));
    assign id_ok   = !use_id || glob[i] || (id[i] == q_id);
    assign hits[i] = valid[i] && id_ok && (((tag[i] ^ q_va) & keep) == '0);
  end
endmodule

// File: rtl/tlb_hitsel.sv
module tlb_hitsel #(
  parameter int N    = 8,
  parameter int IDXW = 3
) (
  input  logic [N-1:0]    hits,
  output logic [IDXW-1:0] idx,
  output logic            any,
  output logic            multi
);
  int cnt;
  always_comb begin
    idx = '0;
    cnt = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        idx = IDXW'(i);
        cnt = cnt + 1;
      end
    end
    any   = |hits;
    multi = (cnt > 1);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N    = 8,
  parameter int IDXW = 3
) (
  input  logic [N-1:0]    locked,
  input  logic [IDXW-1:0] ptr,
  output logic [IDXW-1:0] idx,
  output logic            ok
);
  int cand;
  always_comb begin
    ok   = 1'b0;
    idx  = ptr;
    cand = 0;
    // descending scan so the nearest unlocked slot is assigned last
    for (int k = N - 1; k >= 0; k--) begin
      cand = int'(ptr) + k;
      if (cand >= N) cand = cand - N;
      if (!locked[cand]) begin
        ok  = 1'b1;
        idx = IDXW'(cand);
      end
    end
  end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int N   = 8,
  parameter int AW  = 32,
  parameter int IDW = 4,
  parameter int GW  = 4,
  parameter int ATW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           xlate_en,
  input  logic           lock_ctl,
  input  logic           lk_valid,
  input  logic [AW-1:0]  lk_vaddr,
  input  logic [IDW-1:0] lk_asid,
  output logic           res_valid,
  output logic           res_hit,
  output logic [AW-1:0]  res_paddr,
  output logic [GW-1:0]  res_group,
  output logic [ATW-1:0] res_attr,
  output logic           res_multi,
  input  logic           fill_en,
  input  logic [AW-1:0]  fill_vaddr,
  input  logic [AW-1:0]  fill_paddr,
  input  logic [IDW-1:0] fill_asid,
  input  logic [1:0]     fill_size,
  input  logic           fill_global,
  input  logic [GW-1:0]  fill_group,
  input  logic [ATW-1:0] fill_attr,
  output logic           fill_drop,
  input  logic           inv_all,
  input  logic           inv_one,
  input  logic [AW-1:0]  inv_vaddr
);
  localparam int IDXW = (N > 1) ? $clog2(N) : 1;

  function automatic logic [AW-1:0] off_mask(logic [1:0] sz);
    return (AW'(1) << tlb_pkg::pg_shift(sz)) - AW'(1);
  endfunction

  function automatic logic [AW-1:0] compose(logic [AW-1:0] pa, logic [AW-1:0] va,
                                            logic [1:0] sz);
    return (pa & ~off_mask(sz)) | (va & off_mask(sz));
  endfunction

  // table state
  logic [N-1:0]   valid_q, lock_q, glob_q;
  logic [AW-1:0]  tag_q  [N];
  logic [AW-1:0]  pa_q   [N];
  logic [IDW-1:0] id_q   [N];
  logic [1:0]     size_q [N];
  logic [GW-1:0]  grp_q  [N];
  logic [ATW-1:0] attr_q [N];
  logic [IDXW-1:0] ptr_q;

  // named internal events
  logic [N-1:0]    lk_hits, inv_hits;
  logic [IDXW-1:0] sel_idx, vic_idx;
  logic            sel_any, sel_multi, vic_ok;
  logic            cmd_fill, fill_do, fill_block;

  assign cmd_fill   = fill_en && !inv_all && !inv_one;
  assign fill_do    = cmd_fill && vic_ok;
  assign fill_block = cmd_fill && !vic_ok;

  tlb_match #(.N(N), .AW(AW), .IDW(IDW)) u_lk_match (
    .valid(valid_q), .glob(glob_q), .tag(tag_q), .id(id_q), .size(size_q),
    .q_va(lk_vaddr), .q_id(lk_asid), .use_id(1'b1), .hits(lk_hits)
  );

  tlb_match #(.N(N), .AW(AW), .IDW(IDW)) u_inv_match (
    .valid(valid_q), .glob(glob_q), .tag(tag_q), .id(id_q), .size(size_q),
    .q_va(inv_vaddr), .q_id('0), .use_id(1'b0), .hits(inv_hits)
  );

  tlb_hitsel #(.N(N), .IDXW(IDXW)) u_sel (
    .hits(lk_hits), .idx(sel_idx), .any(sel_any), .multi(sel_multi)
  );

  tlb_victim #(.N(N), .IDXW(IDXW)) u_vic (
    .locked(lock_q), .ptr(ptr_q), .idx(vic_idx), .ok(vic_ok)
  );

  // control state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= '0;
      lock_q    <= '0;
      ptr_q     <= '0;
      fill_drop <= 1'b0;
    end else begin
      fill_drop <= fill_block;
      if (inv_all) begin
        valid_q <= '0;
        lock_q  <= '0;
      end else if (inv_one) begin
        valid_q <= valid_q & ~inv_hits;
        lock_q  <= lock_q & ~inv_hits;
      end else if (fill_do) begin
        valid_q[vic_idx] <= 1'b1;
        lock_q[vic_idx]  <= lock_ctl;
        ptr_q <= (int'(vic_idx) == N - 1) ? '0 : vic_idx + IDXW'(1);
      end
    end
  end

  // entry payload, written only by refills
  always_ff @(posedge clk) begin
    if (fill_do) begin
      tag_q[vic_idx]  <= fill_vaddr & ~off_mask(fill_size);
      pa_q[vic_idx]   <= fill_paddr & ~off_mask(fill_size);
      id_q[vic_idx]   <= fill_asid;
      size_q[vic_idx] <= fill_size;
      glob_q[vic_idx] <= fill_global;
      grp_q[vic_idx]  <= fill_group;
      attr_q[vic_idx] <= fill_attr;
    end
  end

  // registered lookup result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_paddr <= '0;
      res_group <= '0;
      res_attr  <= '0;
      res_multi <= 1'b0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= 1'b0;
      res_paddr <= '0;
      res_group <= '0;
      res_attr  <= '0;
      res_multi <= 1'b0;
      if (lk_valid) begin
        if (!xlate_en) begin
          res_hit   <= 1'b1;
          res_paddr <= lk_vaddr;
        end else if (sel_any) begin
          res_hit   <= 1'b1;
          res_paddr <= compose(pa_q[sel_idx], lk_vaddr, size_q[sel_idx]);
          res_group <= grp_q[sel_idx];
          res_attr  <= attr_q[sel_idx];
          res_multi <= sel_multi;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
  parameter int N    = 8,
  parameter int AW   = 32,
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xlate_en,
  input logic            lk_valid,
  input logic [AW-1:0]   lk_vaddr,
  input logic            res_valid,
  input logic            res_hit,
  input logic [AW-1:0]   res_paddr,
  input logic            res_multi,
  input logic            fill_en,
  input logic            fill_drop,
  input logic            inv_all,
  input logic            inv_one,
  input logic [N-1:0]    valid_q,
  input logic [N-1:0]    lock_q,
  input logic            fill_do,
  input logic [IDXW-1:0] vic_idx
);
  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!res_valid && !res_hit && !res_multi));

  assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !xlate_en) |=> (res_hit && res_paddr == $past(lk_vaddr) && !res_multi));

  assert_flush_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0 && lock_q == '0));

  assert_victim_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_do |-> !lock_q[vic_idx]);

  assert_victim_written_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_do |=> valid_q[$past(vic_idx)]);

  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !inv_all && !inv_one && (&lock_q)) |=> (fill_drop && $stable(valid_q)));

  assert_flush_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && fill_en) |=> (valid_q == '0 && !fill_drop));

  assert_multi_is_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_multi |-> (res_hit && res_valid));
endmodule

bind tlb_assoc tlb_assoc_chk #(.N(N), .AW(AW), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .lk_valid(lk_valid),
  .lk_vaddr(lk_vaddr), .res_valid(res_valid), .res_hit(res_hit),
  .res_paddr(res_paddr), .res_multi(res_multi), .fill_en(fill_en),
  .fill_drop(fill_drop), .inv_all(inv_all), .inv_one(inv_one),
  .valid_q(valid_q), .lock_q(lock_q), .fill_do(fill_do), .vic_idx(vic_idx)
);

// File: tb/tlb_assoc_test.sv
module tlb_assoc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlate_en = 1'b1, lock_ctl = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [3:0]  lk_asid = '0;
  logic        res_valid, res_hit, res_multi, fill_drop;
  logic [31:0] res_paddr;
  logic [3:0]  res_group;
  logic [1:0]  res_attr;
  logic        fill_en = 1'b0, fill_global = 1'b0;
  logic [31:0] fill_vaddr = '0, fill_paddr = '0;
  logic [3:0]  fill_asid = '0, fill_group = '0;
  logic [1:0]  fill_size = '0, fill_attr = '0;
  logic        inv_all = 1'b0, inv_one = 1'b0;
  logic [31:0] inv_vaddr = '0;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  tlb_assoc uut (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .lock_ctl(lock_ctl),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .res_valid(res_valid), .res_hit(res_hit), .res_paddr(res_paddr),
    .res_group(res_group), .res_attr(res_attr), .res_multi(res_multi),
    .fill_en(fill_en), .fill_vaddr(fill_vaddr), .fill_paddr(fill_paddr),
    .fill_asid(fill_asid), .fill_size(fill_size), .fill_global(fill_global),
    .fill_group(fill_group), .fill_attr(fill_attr), .fill_drop(fill_drop),
    .inv_all(inv_all), .inv_one(inv_one), .inv_vaddr(inv_vaddr)
  );

  // reference table
  bit        m_v [8], m_l [8], m_g [8];
  bit [31:0] m_tag [8], m_pa [8];
  bit [3:0]  m_id [8], m_grp [8];
  bit [1:0]  m_sz [8], m_at [8];
  int        m_ptr = 0;

  function automatic bit [31:0] msk(bit [1:0] s);
    case (s)
      2'd0:    return 32'h0000_0fff;
      2'd1:    return 32'h0000_3fff;
      2'd2:    return 32'h0007_ffff;
      default: return 32'h007f_ffff;
    endcase
  endfunction

  function automatic bit covers(int i, bit [31:0] va);
    return m_v[i] && ((m_tag[i] & ~msk(m_sz[i])) == (va & ~msk(m_sz[i])));
  endfunction

  // {hit, paddr, group, attr, multi}
  function automatic bit [39:0] expect_look(bit [31:0] va, bit [3:0] id, bit en);
    int first = -1, n = 0;
    if (!en) return {1'b1, va, 4'd0, 2'd0, 1'b0};
    for (int i = 0; i < 8; i++)
      if (covers(i, va) && (m_g[i] || m_id[i] == id)) begin
        if (first < 0) first = i;
        n++;
      end
    if (first < 0) return 40'd0;
    return {1'b1, (m_pa[first] & ~msk(m_sz[first])) | (va & msk(m_sz[first])),
            m_grp[first], m_at[first], n > 1};
  endfunction

  function automatic int find_victim();
    for (int k = 0; k < 8; k++)
      if (!m_l[(m_ptr + k) % 8]) return (m_ptr + k) % 8;
    return -1;
  endfunction

  task automatic check(bit ok, string req, bit [63:0] act, bit [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one command cycle; entered and left at a falling edge
  task automatic step(bit do_lk, bit [31:0] va, bit [3:0] id, bit do_fill,
                      bit do_iall, bit do_ione, bit [31:0] iva, string req);
    bit [39:0] e_look;
    bit        e_drop;
    int        vic;
    e_look = expect_look(va, id, xlate_en);
    vic    = find_victim();
    e_drop = do_fill && !do_iall && !do_ione && (vic < 0);
    lk_valid = do_lk; lk_vaddr = va; lk_asid = id;
    fill_en = do_fill; inv_all = do_iall; inv_one = do_ione; inv_vaddr = iva;
    @(negedge clk);
    lk_valid = 1'b0; fill_en = 1'b0; inv_all = 1'b0; inv_one = 1'b0;
    if (do_lk) begin
      check(res_valid == 1'b1, req, {63'd0, res_valid}, 64'd1);
      check({res_hit, res_paddr, res_group, res_attr, res_multi} == e_look, req,
            {24'd0, res_hit, res_paddr, res_group, res_attr, res_multi},
            {24'd0, e_look});
    end
    check(fill_drop == e_drop, {req, " drop"}, {63'd0, fill_drop}, {63'd0, e_drop});
    if (do_iall) begin
      for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_l[i] = 0; end
    end else if (do_ione) begin
      for (int i = 0; i < 8; i++) if (covers(i, iva)) begin m_v[i] = 0; m_l[i] = 0; end
    end else if (do_fill && vic >= 0) begin
      m_v[vic] = 1; m_l[vic] = lock_ctl; m_g[vic] = fill_global;
      m_tag[vic] = fill_vaddr; m_pa[vic] = fill_paddr; m_id[vic] = fill_asid;
      m_sz[vic] = fill_size; m_grp[vic] = fill_group; m_at[vic] = fill_attr;
      m_ptr = (vic + 1) % 8;
    end
  endtask

  task automatic set_fill(bit [31:0] va, bit [31:0] pa, bit [3:0] id, bit [1:0] sz,
                          bit gl, bit [3:0] grp, bit [1:0] at);
    fill_vaddr = va; fill_paddr = pa; fill_asid = id; fill_size = sz;
    fill_global = gl; fill_group = grp; fill_attr = at;
  endtask

  task automatic fill(bit [31:0] va, bit [31:0] pa, bit [3:0] id, bit [1:0] sz,
                      bit gl, bit [3:0] grp, bit [1:0] at, string req);
    set_fill(va, pa, id, sz, gl, grp, at);
    step(0, 0, 0, 1, 0, 0, 0, req);
  endtask

  task automatic look(bit [31:0] va, bit [3:0] id, string req);
    step(1, va, id, 0, 0, 0, 0, req);
  endtask

  task automatic flush();
    step(0, 0, 0, 0, 1, 0, 0, "R6 flush");
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit [31:0] base;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({res_valid, res_hit, res_paddr, res_group, res_attr, res_multi, fill_drop} == '0,
          "R1 reset outputs", {23'd0, res_valid, res_hit, res_paddr, res_group, res_attr,
          res_multi, fill_drop}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    look(32'h0000_0000, 0, "R1 miss after reset");
    look(32'hDEAD_BEEF, 4'h7, "R1 miss after reset");
    step(0, 32'h1234_0000, 1, 0, 0, 0, 0, "R2 idle cycle");
    check(res_valid == 1'b0, "R2 idle valid", {63'd0, res_valid}, 64'd0);

    // R5: pass-through
    xlate_en = 1'b0;
    for (int k = 0; k < 4; k++) look(32'h8765_4321 ^ (32'h1111_1111 * k), 4'(k), "R5 bypass");
    xlate_en = 1'b1;

    // R3/R4: each page size at first byte, last byte, next page, wrong ID
    for (int s = 0; s < 4; s++) begin
      base = 32'hA580_0000;
      flush();
      fill(base | 32'h7, 32'h3F00_0000 ^ (32'(s) << 24) | 32'h5, 4'(s + 3), 2'(s), 0,
           4'(s * 4 + 1), 2'(s), "R3 fill");
      look(base, 4'(s + 3), "R3 first byte");
      look(base + msk(2'(s)), 4'(s + 3), "R3 last byte");
      look(base + (32'h0000_0123 & msk(2'(s))), 4'(s + 3), "R4 group attr");
      look(base + msk(2'(s)) + 1, 4'(s + 3), "R4 next page miss");
      look(base, 4'(s + 4), "R3 wrong id");
    end

    // R3: ID sweep over per-ID entries, then a global entry
    flush();
    for (int k = 0; k < 8; k++)
      fill(32'h0040_0000, 32'h6000_0000 + (32'(k) << 12), 4'(k), 0, 0, 4'(k), 2'(k), "R3 id fill");
    for (int k = 0; k < 16; k++) look(32'h0040_0abc, 4'(k), "R3 id sweep");
    flush();
    fill(32'h0041_0000, 32'h7700_0000, 4'h5, 0, 1, 4'hC, 2'h3, "R3 global fill");
    for (int k = 0; k < 16; k++) look(32'h0041_0fff, 4'(k), "R3 global sweep");

    // R8: round robin over a full wrap
    flush();
    for (int k = 0; k < 9; k++)
      fill(32'h1000_0000 + (32'(k) << 12), 32'h5000_0000 + (32'(k) << 12), 1, 0, 0, 4'(k), 0, "R8 fill");
    for (int k = 0; k < 9; k++) look(32'h1000_0010 + (32'(k) << 12), 1, "R8 round robin");

    // R8: locked entries skipped
    flush();
    lock_ctl = 1'b1;
    for (int k = 0; k < 2; k++)
      fill(32'h2000_0000 + (32'(k) << 12), 32'h2100_0000 + (32'(k) << 12), 2, 0, 0, 1, 1, "R8 lock fill");
    lock_ctl = 1'b0;
    for (int k = 2; k < 9; k++)
      fill(32'h2000_0000 + (32'(k) << 12), 32'h2100_0000 + (32'(k) << 12), 2, 0, 0, 2, 2, "R8 fill");
    for (int k = 0; k < 9; k++) look(32'h2000_0000 + (32'(k) << 12), 2, "R8 lock skip");

    // R9: all locked
    flush();
    lock_ctl = 1'b1;
    for (int k = 0; k < 8; k++)
      fill(32'h3000_0000 + (32'(k) << 14), 32'h3100_0000 + (32'(k) << 14), 3, 1, 0, 4'(k), 1, "R9 lock fill");
    fill(32'h3F00_0000, 32'h3E00_0000, 3, 0, 0, 9, 2, "R9 full drop");
    lock_ctl = 1'b0;
    fill(32'h3F00_1000, 32'h3E00_1000, 3, 0, 0, 9, 2, "R9 full drop unlocked ctl");
    look(32'h3F00_0000, 3, "R9 dropped miss");
    for (int k = 0; k < 8; k++) look(32'h3000_0000 + (32'(k) << 14), 3, "R9 kept");

    // R7: single invalidation ignores ID and frees the lock
    flush();
    lock_ctl = 1'b1;
    fill(32'h2000_4000, 32'h4400_4000, 9, 1, 0, 1, 1, "R7 fill");
    fill(32'h3000_0000, 32'h4500_0000, 2, 0, 0, 2, 2, "R7 fill");
    fill(32'h4008_0000, 32'h4600_0000, 9, 2, 1, 3, 3, "R7 fill");
    lock_ctl = 1'b0;
    step(0, 0, 0, 0, 0, 1, 32'h2000_6abc, "R7 inv one");
    look(32'h2000_4000, 9, "R7 removed");
    look(32'h3000_0004, 2, "R7 kept");
    look(32'h4008_1000, 1, "R7 kept global");
    step(0, 0, 0, 0, 0, 1, 32'h5000_0000, "R7 inv no match");
    look(32'h3000_0ff0, 2, "R7 no match kept");
    for (int k = 0; k < 6; k++)
      fill(32'h5000_0000 + (32'(k) << 12), 32'h5500_0000, 0, 0, 0, 0, 0, "R7 freed slot fill");
    look(32'h5000_5000, 0, "R7 freed slot used");

    // R10: command precedence
    flush();
    fill(32'h6000_0000, 32'h6100_0000, 1, 0, 0, 1, 1, "R10 fill");
    set_fill(32'h6000_8000, 32'h6200_0000, 1, 0, 0, 2, 2);
    step(0, 0, 0, 1, 1, 0, 0, "R10 flush beats fill");
    look(32'h6000_8000, 1, "R10 fill ignored");
    look(32'h6000_0000, 1, "R10 flushed");
    fill(32'h6000_0000, 32'h6100_0000, 1, 0, 0, 1, 1, "R10 fill");
    set_fill(32'h6000_8000, 32'h6200_0000, 1, 0, 0, 2, 2);
    step(0, 0, 0, 1, 0, 1, 32'h6000_0000, "R10 inv one beats fill");
    look(32'h6000_8000, 1, "R10 fill ignored");
    look(32'h6000_0000, 1, "R10 entry removed");

    // R11: overlapping pages
    flush();
    fill(32'h0080_0000, 32'h1100_0000, 1, 3, 0, 3, 1, "R11 fill");
    fill(32'h0080_1000, 32'h2200_0000, 1, 0, 0, 7, 2, "R11 fill");
    look(32'h0080_1234, 1, "R11 multi hit");
    look(32'h0080_2000, 1, "R11 single hit");

    // R12: lookup alongside a flush sees the old table
    step(1, 32'h0080_1234, 1, 0, 1, 0, 0, "R12 old contents");
    look(32'h0080_1234, 1, "R12 after flush");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule